// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block gathers single-cycle event pulses from the receive path, the transmit path, the statistics counters and the PHY monitor of an Ethernet MAC into a sticky 16-bit pending register. A 16-bit enable register selects which pending events may assert the single level-high interrupt line. Pending events survive masking. If a source is enabled again while its bit is still pending, the interrupt asserts again.

Host software reaches two registers through a one-cycle read/write strobe interface, with a one-bit address. Reading the pending register returns the events that have accumulated and clears them in the same edge. An event that arrives in that same cycle is not lost: it stays pending for the next read. A typical interrupt handler saves the enable register, writes zero to it, reads and clears the pending register, services the events and then writes the saved value back.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the pending register and the enable register are zero, `irq_o` is low and `rdata_o` is zero.
- R2: The defined event bits are: 0x0001 receive done, 0x0002 no receive descriptor, 0x0004 receive FIFO full, 0x0008 receive early, 0x0010 transmit done, 0x0080 transmit early, 0x0100 counter overflow, 0x0200 PHY link change. A pulse on a defined bit of `evt_i` sets that pending bit at the clock edge. The bit stays set until the pending register is read.
- R3: A read strobe with `addr_i`=0 (pending register) loads the pending bits into `rdata_o` at that edge and clears them. `rdata_o` holds its value until the next read.
- R4: An event pulse in the same cycle as a clearing read is not returned by that read and is still pending afterwards.
- R5: Undefined bits (all bits outside 0x039F) never become pending. They read as zero from both registers, whatever is driven on `evt_i` or written.
- R6: `irq_o` is high exactly when some bit is both pending and enabled. It reflects register state from the edge that updated it.
- R7: A write with `addr_i`=1 loads the enable register. Writing zero drops `irq_o` without changing pending bits. Writing the saved value back restores `irq_o`.
- R8: Events on masked sources still set their pending bits. Enabling such a source raises `irq_o` right after the write edge.
- R9: A write with `addr_i`=0 has no effect on the pending bits.
- R10: A read with `addr_i`=1 returns the enable register and leaves the pending bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 16 | Event pulses, one bit per source |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | 0 selects pending register, 1 selects enable register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Level-high interrupt request |

## Verification
Each of the sixteen event bits is pulsed alone with all sources masked. This separates the defined bits from the undefined ones and shows that masked events still latch. A full sweep of every single-bit enable against every single-bit event checks that the interrupt tracks only the matching pair, which would expose a swapped or stuck enable bit. Directed sequences cover an event that lands on the clearing read, masking and then restoring a subset of sources, writes to the pending address, and reads of the enable register. Together these show that clearing, masking and read-back never lose or invent a pending bit.

// File: rtl/irq_unit_pkg.sv
`timescale 1ns/1ps
// Package: event bit encoding and register select codes for the interrupt unit.
// Assumes a 16-bit register width; bit positions are fixed by software.
package irq_unit_pkg;
    localparam int REG_W = 16;
    localparam logic [REG_W-1:0] EV_RX_DONE   = 16'h0001;
    localparam logic [REG_W-1:0] EV_RX_NODESC = 16'h0002;
    localparam logic [REG_W-1:0] EV_RX_FULL   = 16'h0004;
    localparam logic [REG_W-1:0] EV_RX_EARLY  = 16'h0008;
    localparam logic [REG_W-1:0] EV_TX_DONE   = 16'h0010;
    localparam logic [REG_W-1:0] EV_TX_EARLY  = 16'h0080;
    localparam logic [REG_W-1:0] EV_CNT_OVF   = 16'h0100;
    localparam logic [REG_W-1:0] EV_LINK_CHG  = 16'h0200;
    localparam logic [REG_W-1:0] EV_DEFINED   = EV_RX_DONE | EV_RX_NODESC | EV_RX_FULL |
                                                EV_RX_EARLY | EV_TX_DONE | EV_TX_EARLY |
                                                EV_CNT_OVF | EV_LINK_CHG;
    localparam logic SEL_PENDING = 1'b0;
    localparam logic SEL_ENABLE  = 1'b1;
endpackage

// File: rtl/irq_event_latch.sv
`timescale 1ns/1ps
// Module: sticky pending register. Each defined bit is set by an event pulse
// and cleared by a clearing read; a pulse in the clear cycle wins.
// Assumes clr_i is a single-cycle strobe. Undefined bits are tied to zero.
module irq_event_latch #(
    parameter int              W     = 16,
    parameter logic [W-1:0]    VALID = 16'h039F
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         clr_i,
    output logic [W-1:0] pend_o
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            if (VALID[i]) begin : g_live
                logic bit_q;
                // Purpose: hold one pending event until a clearing read.
                always_ff @(posedge clk) begin
                    if (!rst_n)        bit_q <= 1'b0;
                    else if (evt_i[i]) bit_q <= 1'b1;
                    else if (clr_i)    bit_q <= 1'b0;
                end
                assign pend_o[i] = bit_q;
            end else begin : g_dead
                assign pend_o[i] = 1'b0;
            end
        end
    endgenerate

    // R2: pending bits never drop without a clearing read.
    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((pend_o & $past(pend_o)) == $past(pend_o)));
    // R4: a defined event is pending after its edge, even during a clear.
    assert_keep_new_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_i & VALID) != '0) |=> ((pend_o & $past(evt_i & VALID)) == $past(evt_i & VALID)));
    // R3: a clear leaves only the events of the clearing cycle.
    assert_clear_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((pend_o & ~$past(evt_i)) == '0));
endmodule

// File: rtl/irq_enable_reg.sv
`timescale 1ns/1ps
// Module: enable (mask) register. Loads the defined bits of write data on a
// write strobe; undefined bits stay zero. Assumes wr_i is already decoded.
module irq_enable_reg #(
    parameter int           W     = 16,
    parameter logic [W-1:0] VALID = 16'h039F
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] en_o
);
    logic [W-1:0] en_q;

    // Purpose: capture the new enable mask on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)    en_q <= '0;
        else if (wr_i) en_q <= wdata_i & VALID;
    end
    assign en_o = en_q;

    // R7: the mask changes only on a write.
    assert_enable_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(en_o));
endmodule

// File: rtl/irq_readback.sv
`timescale 1ns/1ps
// Module: registered read-data path. On a read strobe it captures the selected
// register; otherwise it holds. Assumes sel_i uses the package select codes.
module irq_readback #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_i,
    input  logic         sel_i,
    input  logic [W-1:0] pend_i,
    input  logic [W-1:0] en_i,
    output logic [W-1:0] rdata_o
);
    import irq_unit_pkg::*;
    logic [W-1:0] rdata_q;

    // Purpose: latch the addressed register value for the host.
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata_q <= '0;
        else if (rd_i) rdata_q <= (sel_i == SEL_ENABLE) ? en_i : pend_i;
    end
    assign rdata_o = rdata_q;

    // R3: read data only changes after a read strobe.
    assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/irq_status_unit.sv
`timescale 1ns/1ps
// Module: top of the interrupt status and mask unit. Decodes host strobes,
// keeps the pending and enable registers and drives a level interrupt.
// Assumes single-cycle strobes and events; read and write share addr_i.
module irq_status_unit #(
    parameter int                                W     = irq_unit_pkg::REG_W,
    parameter logic [irq_unit_pkg::REG_W-1:0]    VALID = irq_unit_pkg::EV_DEFINED
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         rd_en_i,
    input  logic         wr_en_i,
    input  logic         addr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] rdata_o,
    output logic         irq_o
);
    import irq_unit_pkg::*;

    logic [W-1:0] pend;
    logic [W-1:0] en;
    logic         clr_pend;
    logic         wr_mask;

    assign clr_pend = rd_en_i && (addr_i == SEL_PENDING);
    assign wr_mask  = wr_en_i && (addr_i == SEL_ENABLE);

    irq_event_latch #(.W(W), .VALID(VALID)) u_latch (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_i(clr_pend), .pend_o(pend)
    );

    irq_enable_reg #(.W(W), .VALID(VALID)) u_enable (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_mask), .wdata_i(wdata_i), .en_o(en)
    );

    irq_readback #(.W(W)) u_rb (
        .clk(clk), .rst_n(rst_n), .rd_i(rd_en_i), .sel_i(addr_i),
        .pend_i(pend), .en_i(en), .rdata_o(rdata_o)
    );

    // Purpose: assert the request while any pending source is enabled.
    assign irq_o = |(pend & en);

    // R7: writing an all-zero mask silences the interrupt at once.
    assert_mask_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == SEL_ENABLE && wdata_i == '0) |=> !irq_o);
    // R9: a write to the pending address never clears pending bits.
    assert_no_pending_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !rd_en_i && addr_i == SEL_PENDING) |=>
            ((pend & $past(pend)) == $past(pend)));
    // R5: undefined bits never appear on read data.
    assert_undef_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_o & ~VALID) == '0);
endmodule

// File: tb/irq_status_unit_test.sv
`timescale 1ns/1ps
// Bench: sweeps event and enable patterns against a model built from the
// requirements; reports through its own counters.
module irq_status_unit_test;
    localparam logic [15:0] VM = 16'h039F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] evt = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        addr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    logic [15:0] m_st = '0;
    logic [15:0] m_en = '0;
    logic [15:0] m_rd = '0;

    always #2 clk = ~clk;

    irq_status_unit uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .rd_en_i(rd_en), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock with the given strobes, then the model advances.
    task automatic cyc(input logic [15:0] ev, input logic rd, input logic wr,
                       input logic a, input logic [15:0] wd);
        evt = ev; rd_en = rd; wr_en = wr; addr = a; wdata = wd;
        @(posedge clk); #1;
        if (rd) m_rd = a ? m_en : m_st;
        if (rd && !a) m_st = '0;
        m_st = m_st | (ev & VM);
        if (wr && a) m_en = wd & VM;
        evt = '0; rd_en = 1'b0; wr_en = 1'b0; addr = 1'b0; wdata = '0;
    endtask

    task automatic chk_irq(input string tag);
        chk(tag, {15'd0, irq}, {15'd0, |(m_st & m_en)});
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        chk("R1 rdata", rdata, 16'h0);
        chk("R1 irq", {15'd0, irq}, 16'h0);
        cyc('0, 1, 0, 1, '0);
        chk("R1 enable", rdata, 16'h0);
        cyc('0, 1, 0, 0, '0);
        chk("R1 pending", rdata, 16'h0);

        // R2/R5/R8: each event bit alone with everything masked
        for (int b = 0; b < 16; b++) begin
            cyc(16'(1) << b, 0, 0, 0, '0);
            chk("R8 masked irq", {15'd0, irq}, 16'h0);
            cyc('0, 0, 0, 0, '0);
            cyc('0, 1, 0, 0, '0);
            chk(VM[b] ? "R2 pending bit" : "R5 undefined bit", rdata, (16'(1) << b) & VM);
            cyc('0, 1, 0, 0, '0);
            chk("R3 cleared", rdata, 16'h0);
        end

        // R5: undefined enable bits read zero
        cyc('0, 0, 1, 1, 16'hFFFF);
        cyc('0, 1, 0, 1, '0);
        chk("R5 enable readback", rdata, VM);
        cyc(16'hFFFF, 0, 0, 0, '0);
        cyc('0, 1, 0, 0, '0);
        chk("R5 all events", rdata, VM);

        // R6: every single-bit enable against every single-bit event
        for (int e = 0; e < 16; e++) begin
            cyc('0, 0, 1, 1, 16'(1) << e);
            for (int b = 0; b < 16; b++) begin
                cyc(16'(1) << b, 0, 0, 0, '0);
                chk("R6 irq", {15'd0, irq}, {15'd0, (e == b) && VM[b]});
                cyc('0, 1, 0, 0, '0);
                chk_irq("R6 irq after clear");
            end
        end

        // R4: event on the clearing read stays pending
        cyc(16'h0001, 0, 0, 0, '0);
        cyc(16'h0010, 1, 0, 0, '0);
        chk("R4 read excludes new", rdata, 16'h0001);
        cyc('0, 1, 0, 0, '0);
        chk("R4 new kept", rdata, 16'h0010);

        // R7: mask all, then restore a saved subset
        cyc('0, 0, 1, 1, 16'h0017);
        cyc(16'h0004, 0, 0, 0, '0);
        chk("R7 irq subset", {15'd0, irq}, 16'h1);
        cyc('0, 0, 1, 1, 16'h0000);
        chk("R7 masked", {15'd0, irq}, 16'h0);
        cyc('0, 0, 1, 1, 16'h0017);
        chk("R7 restored", {15'd0, irq}, 16'h1);
        cyc('0, 1, 0, 0, '0);
        chk("R7 pending kept", rdata, 16'h0004);

        // R8: pending masked source raises irq once enabled
        cyc('0, 0, 1, 1, 16'h0000);
        cyc(16'h0200, 0, 0, 0, '0);
        chk("R8 still low", {15'd0, irq}, 16'h0);
        cyc('0, 0, 1, 1, 16'h0200);
        chk("R8 raised", {15'd0, irq}, 16'h1);

        // R9: write to pending address ignored
        cyc('0, 0, 1, 0, 16'hFFFF);
        chk_irq("R9 irq");
        cyc('0, 0, 1, 0, 16'h0000);
        cyc('0, 1, 0, 0, '0);
        chk("R9 pending", rdata, 16'h0200);

        // R10: enable read has no side effect
        cyc(16'h0100, 0, 0, 0, '0);
        cyc('0, 1, 0, 1, '0);
        chk("R10 enable value", rdata, 16'h0200);
        cyc('0, 1, 0, 1, '0);
        cyc('0, 1, 0, 0, '0);
        chk("R10 pending kept", rdata, 16'h0100);
        chk("R10 model", rdata, m_rd);

        // R1: reset clears everything again
        cyc(16'h0001, 0, 1, 1, 16'h0001);
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        chk("R1 irq after reset", {15'd0, irq}, 16'h0);
        chk("R1 rdata after reset", rdata, 16'h0);
        finish_run();
    end
endmodule